// File: doc/BRIEF.md
# Single-Slot Packet Timestamp Capture

This block stamps packet timing events with the running time-counter value. The packet classifier gives a one-cycle strobe for a transmit event or a receive event, and the receive strobe comes with a small event-kind code. When the matching direction is enabled and its slot is free, the block copies the 64-bit time input into that direction's stamp register. It then marks the slot valid and locks it. Software reads the stamp as two 32-bit words, low word first. The read of the high word releases the slot, so a held stamp can never be overwritten by a later event.

A small word-addressed register port holds the configuration:
- a control word for each direction, with an enable and a read-only valid flag;
- a receive filter field that chooses which event kinds are stamped;
- a mask for the transmit-ready interrupt;
- a write-one-to-clear interrupt status bit.

The time counter and the packet classification are outside the block.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset every register reads zero, both slots are unlocked and `irq` is low.
- R2: A `txEvent` strobe that arrives while transmit is enabled (address 0, bit 0) and the slot is free copies `timeNow` into the transmit stamp at that clock edge. From the next cycle, address 0 bit 1 (valid) reads 1, address 2 returns bits 31:0 and address 3 returns bits 63:32.
- R3: While a direction's valid bit is set, further strobes in that direction leave its stamp and valid bit unchanged.
- R4: A read of the high word (address 3 for transmit, address 5 for receive) clears that direction's valid bit. A read of the low word (address 2 or 4) does not.
- R5: A strobe in the same cycle as the high-word read of its own direction is captured. The read returns the old high word, the valid bit stays set and the stamp takes the new time.
- R6: With a direction's enable at 0, its strobes are ignored, and a stamp already held stays readable and valid.
- R7: Receive control (address 1) has enable in bit 0, valid in bit 1 and a filter in bits 3:2. The filter codes are:
  - 0: every kind is stamped;
  - 1: only kind 0;
  - 2: only kind 1;
  - 3: only kinds below 4.
- R8: Each transmit capture sets the status bit (address 7, bit 0). `irq` equals status AND mask (address 6, bit 0). Receive captures never set the status bit.
- R9: Writing 1 to address 7 bit 0 clears the status bit, and writing 0 leaves it unchanged. The status bit and the valid bits do not affect each other.
- R10: The two directions are independent. Receive events and receive reads leave the transmit stamp and valid bit untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeNow | input | 64 | Current time-counter value |
| txEvent | input | 1 | Transmit timing event strobe |
| rxEvent | input | 1 | Receive timing event strobe |
| rxKind | input | 3 | Event kind code that comes with `rxEvent` |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; its side effects apply at the clock edge |
| regAddr | input | 3 | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, valid in the same cycle |
| irq | output | 1 | Transmit-stamp-ready interrupt |

## Verification
Three stimulus patterns are used:
- isolated strobes, which show that a capture happens and that both halves of the word land in place;
- strobes that reach a locked slot, which tell a lock that holds apart from a slot that is silently overwritten;
- a strobe that coincides with the high-word read, which separates release-then-capture from the two wrong orders.

Receive strobes are swept across all four filter codes with kinds that should pass and kinds that should not. Interleaved mask writes, status clears and reads check that status, mask and valid stay separate.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int TIME_W  = 64;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int KIND_W  = 3;
  localparam int NUM_DIR = 2;
  localparam int DIR_TX  = 0;
  localparam int DIR_RX  = 1;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_TX_CTRL = 3'd0,
    ADDR_RX_CTRL = 3'd1,
    ADDR_TX_LO   = 3'd2,
    ADDR_TX_HI   = 3'd3,
    ADDR_RX_LO   = 3'd4,
    ADDR_RX_HI   = 3'd5,
    ADDR_IRQ_MSK = 3'd6,
    ADDR_IRQ_STS = 3'd7
  } regAddr_e;

  typedef enum logic [1:0] {
    FILT_ALL   = 2'd0,
    FILT_KIND0 = 2'd1,
    FILT_KIND1 = 2'd2,
    FILT_CLASS = 2'd3
  } rxFilt_e;

  // strobes from control to datapath: load a direction's stamp register
  typedef struct packed {
    logic [NUM_DIR-1:0] capture;
  } capStrobe_t;
endpackage

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [TIME_W-1:0]              timeNow,
  input  capStrobe_t                     capStb,
  output logic [NUM_DIR-1:0][TIME_W-1:0] stampWords
);
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_slot
    logic [TIME_W-1:0] stampQ;
    always_ff @(posedge clk) begin
      if (!rstN)                  stampQ <= '0;
      else if (capStb.capture[d]) stampQ <= timeNow;
    end
    assign stampWords[d] = stampQ;
  end
endmodule

// File: rtl/tsc_control.sv
module tsc_control
  import tsc_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           txEvent,
  input  logic                           rxEvent,
  input  logic [KIND_W-1:0]              rxKind,
  input  logic                           regWr,
  input  logic                           regRd,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [WORD_W-1:0]              regWdata,
  input  logic [NUM_DIR-1:0][TIME_W-1:0] stampWords,
  output logic [WORD_W-1:0]              regRdata,
  output logic                           irq,
  output capStrobe_t                     capStb,
  output logic [NUM_DIR-1:0]             enVec,
  output logic [NUM_DIR-1:0]             validVec
);
  localparam int CLASS_LIMIT = 2 ** (KIND_W - 1);

  logic [NUM_DIR-1:0] enQ, validQ, hiRead, eventVec, ctrlWr;
  rxFilt_e            filtQ;
  logic               maskQ, statQ, rxPass;
  logic               mskWr, stsWr;

  assign ctrlWr[DIR_TX] = regWr && (regAddr == ADDR_TX_CTRL);
  assign ctrlWr[DIR_RX] = regWr && (regAddr == ADDR_RX_CTRL);
  assign mskWr          = regWr && (regAddr == ADDR_IRQ_MSK);
  assign stsWr          = regWr && (regAddr == ADDR_IRQ_STS);
  assign hiRead[DIR_TX] = regRd && (regAddr == ADDR_TX_HI);
  assign hiRead[DIR_RX] = regRd && (regAddr == ADDR_RX_HI);

  always_comb begin
    case (filtQ)
      FILT_ALL:   rxPass = 1'b1;
      FILT_KIND0: rxPass = (rxKind == KIND_W'(0));
      FILT_KIND1: rxPass = (rxKind == KIND_W'(1));
      default:    rxPass = (int'(rxKind) < CLASS_LIMIT);
    endcase
  end

  assign eventVec[DIR_TX] = txEvent;
  assign eventVec[DIR_RX] = rxEvent && rxPass;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    // a high-word read frees the slot in the same cycle an event may refill it
    assign capStb.capture[d] = enQ[d] && eventVec[d] && (!validQ[d] || hiRead[d]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ[d]    <= 1'b0;
        validQ[d] <= 1'b0;
      end else begin
        if (ctrlWr[d])               enQ[d]    <= regWdata[0];
        if (capStb.capture[d])       validQ[d] <= 1'b1;
        else if (hiRead[d])          validQ[d] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtQ <= FILT_ALL;
      maskQ <= 1'b0;
      statQ <= 1'b0;
    end else begin
      if (ctrlWr[DIR_RX])               filtQ <= rxFilt_e'(regWdata[3:2]);
      if (mskWr)                        maskQ <= regWdata[0];
      if (capStb.capture[DIR_TX])       statQ <= 1'b1;
      else if (stsWr && regWdata[0])    statQ <= 1'b0;
    end
  end

  assign irq      = statQ & maskQ;
  assign enVec    = enQ;
  assign validVec = validQ;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_TX_CTRL: regRdata[1:0] = {validQ[DIR_TX], enQ[DIR_TX]};
      ADDR_RX_CTRL: regRdata[3:0] = {filtQ, validQ[DIR_RX], enQ[DIR_RX]};
      ADDR_TX_LO:   regRdata = stampWords[DIR_TX][WORD_W-1:0];
      ADDR_TX_HI:   regRdata = stampWords[DIR_TX][TIME_W-1:WORD_W];
      ADDR_RX_LO:   regRdata = stampWords[DIR_RX][WORD_W-1:0];
      ADDR_RX_HI:   regRdata = stampWords[DIR_RX][TIME_W-1:WORD_W];
      ADDR_IRQ_MSK: regRdata[0] = maskQ;
      default:      regRdata[0] = statQ;
    endcase
  end
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [63:0]       timeNow,
  input  logic              txEvent,
  input  logic              rxEvent,
  input  logic [2:0]        rxKind,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq
);
  capStrobe_t                     capStb;
  logic [NUM_DIR-1:0][TIME_W-1:0] stampWords;
  logic [NUM_DIR-1:0]             enVec, validVec;

  tsc_control u_ctrl (
    .clk(clk), .rstN(rstN), .txEvent(txEvent), .rxEvent(rxEvent), .rxKind(rxKind),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .stampWords(stampWords), .regRdata(regRdata), .irq(irq), .capStb(capStb),
    .enVec(enVec), .validVec(validVec)
  );

  tsc_datapath u_dp (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .capStb(capStb), .stampWords(stampWords)
  );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
  import tsc_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic [63:0]                    timeNow,
  input logic                           txEvent,
  input logic                           regWr,
  input logic                           regRd,
  input logic [2:0]                     regAddr,
  input logic                           irq,
  input logic [NUM_DIR-1:0]             enVec,
  input logic [NUM_DIR-1:0]             validVec,
  input logic [NUM_DIR-1:0][TIME_W-1:0] stampWords
);
  p_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enVec[DIR_TX] && txEvent && !validVec[DIR_TX])
      |=> (validVec[DIR_TX] && stampWords[DIR_TX] == $past(timeNow)));

  p_lock_tx_r3: assert property (@(posedge clk) disable iff (!rstN)
    (validVec[DIR_TX] && !(regRd && regAddr == ADDR_TX_HI))
      |=> (validVec[DIR_TX] && $stable(stampWords[DIR_TX])));

  p_lock_rx_r3: assert property (@(posedge clk) disable iff (!rstN)
    (validVec[DIR_RX] && !(regRd && regAddr == ADDR_RX_HI))
      |=> (validVec[DIR_RX] && $stable(stampWords[DIR_RX])));

  p_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (validVec[DIR_TX] && regRd && regAddr == ADDR_TX_HI && !txEvent) |=> !validVec[DIR_TX]);

  p_disabled_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enVec[DIR_RX] |=> $stable(stampWords[DIR_RX]));

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!irq && !txEvent && !regWr) |=> !irq);
endmodule

bind ts_capture_unit tsc_checker u_chk (.*);

// File: tb/ts_capture_unit_tb.sv
module ts_capture_unit_tb;
  import tsc_pkg::*;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] timeNow;
  logic        txEvent, rxEvent, regWr, regRd;
  logic [2:0]  rxKind, regAddr;
  logic [31:0] regWdata, regRdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  typedef struct { logic [31:0] data; string tag; } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  ts_capture_unit u_dut (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .txEvent(txEvent), .rxEvent(rxEvent),
    .rxKind(rxKind), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  // monitor: compares read data with the queued expectation
  always @(negedge clk) begin
    if (rstN && regRd) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expectation, got %h", regRdata);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (regRdata !== it.data) begin
          errors++;
          $display("FAIL %s: addr %0d got %h expected %h", it.tag, regAddr, regRdata, it.data);
        end
      end
    end
  end

  task automatic drive(input logic wr, input logic rd, input logic [2:0] a,
                       input logic [31:0] wd, input logic te, input logic re,
                       input logic [2:0] k, input logic [63:0] t);
    @(posedge clk); #1;
    regWr = wr; regRd = rd; regAddr = a; regWdata = wd;
    txEvent = te; rxEvent = re; rxKind = k; timeNow = t;
  endtask

  task automatic idle();
    drive(0, 0, 3'd0, 32'd0, 0, 0, 3'd0, timeNow);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    drive(1, 0, a, d, 0, 0, 3'd0, timeNow);
  endtask

  task automatic rdExp(input logic [2:0] a, input logic [31:0] e, input string tag);
    expItem_t it;
    it.data = e; it.tag = tag;
    expQ.push_back(it);
    drive(0, 1, a, 32'd0, 0, 0, 3'd0, timeNow);
  endtask

  task automatic txEv(input logic [63:0] t);
    drive(0, 0, 3'd0, 32'd0, 1, 0, 3'd0, t);
  endtask

  task automatic rxEv(input logic [2:0] k, input logic [63:0] t);
    drive(0, 0, 3'd0, 32'd0, 0, 1, k, t);
  endtask

  task automatic checkIrq(input logic e, input string tag);
    idle();
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    expItem_t hold;
    rstN = 0; timeNow = '0; txEvent = 0; rxEvent = 0; rxKind = '0;
    regWr = 0; regRd = 0; regAddr = '0; regWdata = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    for (int a = 0; a < 8; a++) rdExp(3'(a), 32'd0, "R1");
    checkIrq(0, "R1");

    // R2 basic capture
    wrReg(ADDR_TX_CTRL, 32'd1);
    rdExp(ADDR_TX_CTRL, 32'd1, "R2");
    txEv(64'h1111_2222_3333_4444);
    rdExp(ADDR_TX_CTRL, 32'd3, "R2");
    rdExp(ADDR_TX_LO, 32'h3333_4444, "R2");
    rdExp(ADDR_TX_CTRL, 32'd3, "R4");          // low read leaves valid set
    // R3 locked slot
    txEv(64'hAAAA_BBBB_CCCC_DDDD);
    rdExp(ADDR_TX_LO, 32'h3333_4444, "R3");
    rdExp(ADDR_TX_HI, 32'h1111_2222, "R2");
    rdExp(ADDR_TX_CTRL, 32'd1, "R4");

    // R5 coincident high read and event
    txEv(64'h0000_0005_0000_0006);
    hold.data = 32'h0000_0005; hold.tag = "R5";
    expQ.push_back(hold);
    drive(0, 1, ADDR_TX_HI, 32'd0, 1, 0, 3'd0, 64'h0000_0007_0000_0008);
    rdExp(ADDR_TX_CTRL, 32'd3, "R5");
    rdExp(ADDR_TX_LO, 32'h0000_0008, "R5");
    rdExp(ADDR_TX_HI, 32'h0000_0007, "R5");
    rdExp(ADDR_TX_CTRL, 32'd1, "R4");

    // R6 disable keeps held stamp
    txEv(64'h0000_0009_0000_000A);
    wrReg(ADDR_TX_CTRL, 32'd0);
    txEv(64'h0000_00FF_0000_00FF);
    rdExp(ADDR_TX_CTRL, 32'd2, "R6");
    rdExp(ADDR_TX_HI, 32'h0000_0009, "R6");
    rdExp(ADDR_TX_CTRL, 32'd0, "R6");
    txEv(64'h0000_0077_0000_0077);
    rdExp(ADDR_TX_CTRL, 32'd0, "R6");
    rdExp(ADDR_TX_LO, 32'h0000_000A, "R6");

    // R8 / R9 interrupt status and mask
    rdExp(ADDR_IRQ_STS, 32'd1, "R8");
    checkIrq(0, "R8");
    wrReg(ADDR_IRQ_MSK, 32'd1);
    checkIrq(1, "R8");
    wrReg(ADDR_IRQ_STS, 32'd0);
    rdExp(ADDR_IRQ_STS, 32'd1, "R9");
    wrReg(ADDR_IRQ_STS, 32'd1);
    rdExp(ADDR_IRQ_STS, 32'd0, "R9");
    checkIrq(0, "R9");
    wrReg(ADDR_TX_CTRL, 32'd1);
    txEv(64'h0000_0100_0000_0200);
    checkIrq(1, "R8");
    rdExp(ADDR_TX_HI, 32'h0000_0100, "R4");
    rdExp(ADDR_IRQ_STS, 32'd1, "R9");          // high read does not clear status
    wrReg(ADDR_IRQ_STS, 32'd1);
    checkIrq(0, "R9");
    txEv(64'h0000_0300_0000_0400);
    wrReg(ADDR_IRQ_STS, 32'd1);
    rdExp(ADDR_TX_CTRL, 32'd3, "R9");          // clear does not drop valid

    // R7 receive filters, R10 independence (tx slot holds 0x300/0x400)
    wrReg(ADDR_RX_CTRL, 32'h5);                // enable, filter 1
    rxEv(3'd2, 64'h0000_0010_0000_0020);
    rdExp(ADDR_RX_CTRL, 32'h5, "R7");
    rxEv(3'd0, 64'h0000_0011_0000_0021);
    rdExp(ADDR_RX_CTRL, 32'h7, "R7");
    checkIrq(0, "R8");
    rdExp(ADDR_RX_LO, 32'h0000_0021, "R7");
    rdExp(ADDR_RX_HI, 32'h0000_0011, "R7");
    rdExp(ADDR_TX_CTRL, 32'd3, "R10");
    rdExp(ADDR_TX_LO, 32'h0000_0400, "R10");
    wrReg(ADDR_RX_CTRL, 32'h9);                // filter 2
    rxEv(3'd0, 64'h0000_0012_0000_0022);
    rdExp(ADDR_RX_CTRL, 32'h9, "R7");
    rxEv(3'd1, 64'h0000_0013_0000_0023);
    rdExp(ADDR_RX_HI, 32'h0000_0013, "R7");
    wrReg(ADDR_RX_CTRL, 32'hD);                // filter 3
    rxEv(3'd5, 64'h0000_0014_0000_0024);
    rdExp(ADDR_RX_CTRL, 32'hD, "R7");
    rxEv(3'd3, 64'h0000_0015_0000_0025);
    rdExp(ADDR_RX_HI, 32'h0000_0015, "R7");
    wrReg(ADDR_RX_CTRL, 32'h1);                // filter 0
    rxEv(3'd6, 64'h0000_0016_0000_0026);
    rdExp(ADDR_RX_LO, 32'h0000_0026, "R7");
    rdExp(ADDR_RX_HI, 32'h0000_0016, "R7");
    rdExp(ADDR_TX_HI, 32'h0000_0300, "R10");
    idle();
    idle();

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d reads pending expected 0", expQ.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule